// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block runs one read transaction at a time on a serial flash bus with eight data lines, using single transfer rate only. A requester presents a mode select, a start address and a byte count on a valid/ready request port. The mode select fixes the opcode, the address length, whether dummy clocks are inserted and how many lines carry the returned data. The block then drives chip select, the serial clock and the IO lines, and returns the data as a byte stream with valid/ready handshaking.

The serial clock comes from a programmable half-period divider on the system clock, so the bus rate can be placed in the flash's allowed window for any system clock. The divider value is latched when a request is accepted. During the command and address phase only line 0 is driven. Output enables are released before the turnaround so that the flash can drive the bus.

If the consumer stalls the byte stream, the serial clock freezes until the held byte is taken, so no data is lost. A one-cycle done pulse marks the end of each transaction. A busy flag, which is also the inverse of the request ready, blocks new work until then.

Top module: `flash_rd_engine`

## Requirements
- R1: While reset is asserted and after it is released, chip select is high, the serial clock is low, no output enable is set, busy and done are low, request ready is high, no byte is valid, and a request held during reset is not taken.
- R2: Mode 0 sends opcode 03h and then the low 24 address bits, MSB first on IO line 0. Line 0 changes only while the serial clock is low, and only its output enable is set during this phase.
- R3: Mode 1 sends opcode 13h and then all 32 address bits, MSB first on IO line 0.
- R4: Mode 2 sends opcode 7Ch and then 32 address bits. All output enables are released before the first of exactly 8 dummy clocks that follow.
- R5: In modes 0, 1 and 3, data is sampled from IO line 1 on serial clock rising edges, 8 clocks per byte, with the first sampled bit as the MSB of the byte.
- R6: In mode 2, each serial clock rising edge captures one whole byte from IO lines 7..0, with line 7 as the MSB.
- R7: Each serial clock half period lasts (divider value + 1) system clocks, and the clock rests low whenever chip select is high.
- R8: Exactly the requested number of bytes is delivered, with a count of 0 taken as 1. A single-cycle done pulse follows, one half period after the last sampling edge when the stream is not stalled, and chip select rises in the same cycle.
- R9: Chip select stays low for the whole transaction and is high for at least one clock between transactions.
- R10: Busy rises one clock after a request is taken and stays high until done. Requests presented while busy are ignored.
- R11: While a byte is valid but not accepted, the byte, the serial clock and chip select hold their values.
- R12: Mode 3 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Half-period length minus one, in system clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_mode | input | 2 | 0 basic read, 1 wide-address read, 2 octal fast read, 3 same as 0 |
| req_addr | input | 32 | Start address |
| req_len | input | LEN_W | Number of bytes to read (0 means 1) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| flash_cs_n | output | 1 | Active-low chip select |
| flash_sck | output | 1 | Serial clock |
| flash_io_out | output | 8 | IO line output values |
| flash_io_oe | output | 8 | IO line output enables |
| flash_io_in | input | 8 | IO line input values |
| out_valid | output | 1 | Data byte present |
| out_data | output | 8 | Data byte |
| out_ready | input | 1 | Consumer takes the byte |

## Verification
Busy and the loss of request ready are due one clock after the accepting edge. The first serial clock rise is due (divider + 1) clocks after chip select falls. A byte becomes valid in the clock that follows the rising edge that completes it, and done and the chip select release come one further half period later. The bench samples every output on the falling system clock edge. A bus model in the bench watches serial clock transitions there, counts the system clocks between them and the rising edges per phase, and decodes the opcode and address it receives. The bench then compares the done timing, the byte count and the clock count against values computed from the requested mode, divider and length, rather than waiting a fixed number of cycles.

// File: rtl/flash_rd_pkg.sv
`timescale 1ns/1ps
package flash_rd_pkg;

  typedef enum logic [1:0] {
    FR_BASIC = 2'd0,
    FR_WIDE  = 2'd1,
    FR_OCTAL = 2'd2,
    FR_ALT   = 2'd3
  } fr_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEND = 3'd1,
    ST_WAIT = 3'd2,
    ST_RECV = 3'd3,
    ST_STOP = 3'd4,
    ST_GAP  = 3'd5
  } fr_state_e;

  localparam logic [7:0] OP_BASIC = 8'h03;
  localparam logic [7:0] OP_WIDE  = 8'h13;
  localparam logic [7:0] OP_OCTAL = 8'h7C;

  localparam int unsigned IO_W       = 8;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned HDR_SHORT  = 32;
  localparam int unsigned HDR_LONG   = 40;
  localparam int unsigned DUMMY_CLKS = 8;
  localparam int unsigned CNT_W      = 6;

endpackage

// File: rtl/fr_tick_gen.sv
`timescale 1ns/1ps
module fr_tick_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == div_i);
  assign tick   = run && !hold && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (!hold) begin
      cnt_d = at_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fr_cmd_shift.sv
`timescale 1ns/1ps
module fr_cmd_shift
  import flash_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output logic              tx_bit
);

  localparam int unsigned SR_W = HDR_LONG;

  logic [SR_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load) begin
      sr_d = wide ? {opcode, addr} : {opcode, addr[23:0], 8'h00};
    end else if (shift) begin
      sr_d = {sr_q[SR_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load || shift) begin
      sr_q <= sr_d;
    end
  end

  assign tx_bit = sr_q[SR_W-1];

endmodule

// File: rtl/fr_rx_capture.sv
`timescale 1ns/1ps
module fr_rx_capture
  import flash_rd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            cap,
  input  logic            octal,
  input  logic [IO_W-1:0] io_in,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            byte_end
);

  logic [6:0] sr_q, sr_d;
  logic [2:0] bcnt_q, bcnt_d;
  logic       valid_q, valid_d;
  logic [7:0] data_q, data_d;

  assign byte_end = octal || (bcnt_q == 3'd7);

  always_comb begin
    sr_d    = sr_q;
    bcnt_d  = bcnt_q;
    valid_d = valid_q;
    data_d  = data_q;
    if (out_ready) valid_d = 1'b0;
    if (clr) begin
      bcnt_d = '0;
    end else if (cap) begin
      if (octal) begin
        data_d  = io_in;
        valid_d = 1'b1;
      end else begin
        sr_d   = {sr_q[5:0], io_in[1]};
        bcnt_d = bcnt_q + 1'b1;
        if (byte_end) begin
          data_d  = {sr_q, io_in[1]};
          valid_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      bcnt_q  <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      bcnt_q  <= bcnt_d;
      if (cap) begin
        sr_q   <= sr_d;
        data_q <= data_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

endmodule

// File: rtl/flash_rd_engine.sv
`timescale 1ns/1ps
module flash_rd_engine
  import flash_rd_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_mode,
  input  logic [31:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic              flash_cs_n,
  output logic              flash_sck,
  output logic [7:0]        flash_io_out,
  output logic [7:0]        flash_io_oe,
  input  logic [7:0]        flash_io_in,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready
);

  localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(HDR_LONG);
  localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(HDR_SHORT);
  localparam logic [CNT_W-1:0] CNT_DUMMY = CNT_W'(DUMMY_CLKS);
  localparam logic [LEN_W-1:0] LEN_ONE   = LEN_W'(1);

  fr_state_e         state_q, state_d;
  logic              sck_q, sck_d;
  logic              cs_n_q, cs_n_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              octal_q, wide_q;
  logic [DIV_W-1:0]  div_q;

  fr_mode_e          mode_in;
  logic              octal_in, wide_in, accept;
  logic [7:0]        opcode_in;
  logic [CNT_W-1:0]  hdr_bits;
  logic              tick, hold, tx_shift, tx_bit, rx_cap, byte_end;
  logic              sending;

  assign mode_in   = fr_mode_e'(req_mode);
  assign octal_in  = (mode_in == FR_OCTAL);
  assign wide_in   = (mode_in == FR_WIDE) || octal_in;
  assign opcode_in = octal_in ? OP_OCTAL : (wide_in ? OP_WIDE : OP_BASIC);
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign hdr_bits  = wide_q ? CNT_LONG : CNT_SHORT;
  assign hold      = out_valid && !out_ready;
  assign sending   = (state_q == ST_SEND);

  fr_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q != ST_IDLE),
    .hold  (hold),
    .div_i (div_q),
    .tick  (tick)
  );

  fr_cmd_shift u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .shift  (tx_shift),
    .opcode (opcode_in),
    .addr   (req_addr),
    .wide   (wide_in),
    .tx_bit (tx_bit)
  );

  fr_rx_capture u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept),
    .cap       (rx_cap),
    .octal     (octal_q),
    .io_in     (flash_io_in),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .byte_end  (byte_end)
  );

  always_comb begin
    state_d  = state_q;
    sck_d    = sck_q;
    cs_n_d   = cs_n_q;
    done_d   = 1'b0;
    cnt_d    = cnt_q;
    left_d   = left_q;
    tx_shift = 1'b0;
    rx_cap   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_SEND;
          cs_n_d  = 1'b0;
          sck_d   = 1'b0;
          cnt_d   = '0;
          left_d  = (req_len == '0) ? LEN_ONE : req_len;
        end
      end
      ST_SEND: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d = 1'b1;
            cnt_d = cnt_q + 1'b1;
          end else begin
            sck_d = 1'b0;
            if (cnt_q == hdr_bits) begin
              cnt_d   = '0;
              state_d = octal_q ? ST_WAIT : ST_RECV;
            end else begin
              tx_shift = 1'b1;
            end
          end
        end
      end
      ST_WAIT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d = 1'b1;
            cnt_d = cnt_q + 1'b1;
          end else begin
            sck_d = 1'b0;
            if (cnt_q == CNT_DUMMY) begin
              cnt_d   = '0;
              state_d = ST_RECV;
            end
          end
        end
      end
      ST_RECV: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d  = 1'b1;
            rx_cap = 1'b1;
            if (byte_end) begin
              if (left_q == LEN_ONE) state_d = ST_STOP;
              else                   left_d  = left_q - 1'b1;
            end
          end else begin
            sck_d = 1'b0;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          sck_d   = 1'b0;
          cs_n_d  = 1'b1;
          done_d  = 1'b1;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tick) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      octal_q <= 1'b0;
      wide_q  <= 1'b0;
      div_q   <= '0;
    end else if (accept) begin
      octal_q <= octal_in;
      wide_q  <= wide_in;
      div_q   <= clk_div;
    end
  end

  for (genvar g = 0; g < IO_W; g++) begin : g_lane
    if (g == 0) begin : g_tx
      assign flash_io_out[g] = sending && tx_bit;
      assign flash_io_oe[g]  = sending;
    end else begin : g_in
      assign flash_io_out[g] = 1'b0;
      assign flash_io_oe[g]  = 1'b0;
    end
  end

  assign flash_cs_n = cs_n_q;
  assign flash_sck  = sck_q;
  assign done       = done_q;
  assign busy       = (state_q != ST_IDLE);
  assign req_ready  = !busy;

  // R7: the serial clock rests low whenever the device is deselected
  p_sck_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> !flash_sck);

  // R4: an output enable only during selection and only on line 0
  p_oe_cmd_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|flash_io_oe) |-> (flash_io_oe == 8'h01) && !flash_cs_n);

  // R2: transmitted bits do not move while the clock is high
  p_tx_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flash_sck |-> $stable(flash_io_out));

  // R11: a stalled byte and the bus clock both hold
  p_hold_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));

  p_hold_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(flash_sck) && $stable(flash_cs_n));

  // R8: done is a single-cycle pulse coinciding with deselect
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flash_cs_n);

  // R9: deselected whenever not busy
  p_idle_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> flash_cs_n);

  // R10: a new selection only follows an idle cycle with a request
  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_cs_n) |-> $past(req_valid) && !$past(busy));

endmodule

// File: tb/flash_rd_engine_tb.sv
`timescale 1ns/1ps
module flash_rd_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  clk_div;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_mode;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic        busy, done;
  logic        flash_cs_n, flash_sck;
  logic [7:0]  flash_io_out, flash_io_oe, flash_io_in;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready;

  always #2.5 clk = ~clk;

  flash_rd_engine #(.DIV_W(8), .LEN_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
    .flash_cs_n(flash_cs_n), .flash_sck(flash_sck),
    .flash_io_out(flash_io_out), .flash_io_oe(flash_io_oe),
    .flash_io_in(flash_io_in), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fdat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
  endfunction

  // expectations for the running transaction
  logic [7:0]  exp_op;
  logic [31:0] exp_addr;
  int          exp_len, exp_div;
  bit          exp_octal, exp_stall;
  string       exp_tag;

  // model and collector state
  int          cyc, rx_idx, done_cnt, last_rise, cs_hi, rise_n, half, aw, dm;
  logic [7:0]  m_op, hold_data;
  logic [31:0] m_adr;
  bit          prev_cs, prev_sck, oe_bad, per_bad, hold_prev, hold_sck;

  always @(negedge clk) begin
    logic [7:0] bt;
    logic       b;
    int         idx;
    cyc++;
    if (!rst_n) begin
      prev_cs = 1'b1; prev_sck = 1'b0; hold_prev = 1'b0;
      out_ready = 1'b1; flash_io_in = 8'h00; cs_hi = 0;
    end else begin
      out_ready = exp_stall ? (cyc % 4 == 0) : 1'b1;
      if (hold_prev)
        chk(out_valid && out_data == hold_data && flash_sck == hold_sck,
            "R11", "stalled byte/clock", {out_valid, out_data}, {1'b1, hold_data});
      hold_prev = out_valid && !out_ready;
      hold_data = out_data;
      hold_sck  = flash_sck;
      if (out_valid && out_ready) begin
        chk(out_data == fdat(exp_addr + rx_idx), exp_octal ? "R6" : "R5",
            "data byte", out_data, fdat(exp_addr + rx_idx));
        rx_idx++;
      end
      if (done) begin
        done_cnt++;
        chk(rx_idx == exp_len, "R8", "bytes before done", rx_idx, exp_len);
        if (!exp_stall)
          chk(cyc - last_rise == exp_div + 1, "R8", "done delay",
              cyc - last_rise, exp_div + 1);
      end
      if (flash_cs_n) begin
        if (!prev_cs) begin
          chk(m_op == exp_op, exp_tag, "opcode", m_op, exp_op);
          chk(m_adr == exp_addr, exp_tag, "address", m_adr, exp_addr);
          chk(!oe_bad, exp_octal ? "R4" : "R2", "output enable phase", oe_bad, 0);
          chk(!per_bad, "R7", "half period", per_bad, 0);
          chk(rise_n == 8 + aw + dm + exp_len * (exp_octal ? 1 : 8),
              exp_octal ? "R6" : "R5", "clock count", rise_n,
              8 + aw + dm + exp_len * (exp_octal ? 1 : 8));
          cs_hi = 0;
        end
        cs_hi++;
      end else begin
        if (prev_cs) begin
          chk(cs_hi >= 1, "R9", "deselect gap", cs_hi, 1);
          rise_n = 0; half = 1; m_op = 0; m_adr = 0; aw = 32; dm = 0;
          oe_bad = 0; per_bad = 0;
        end else if (flash_sck != prev_sck) begin
          if (rise_n < 8 && half != exp_div + 1) per_bad = 1;
          half = 1;
          if (flash_sck) begin
            if (flash_io_oe != ((rise_n < 8 + aw) ? 8'h01 : 8'h00)) oe_bad = 1;
            if (rise_n < 8) m_op = {m_op[6:0], flash_io_out[0]};
            else if (rise_n < 8 + aw) m_adr = {m_adr[30:0], flash_io_out[0]};
            if (rise_n == 7) begin
              aw = (m_op == 8'h03) ? 24 : 32;
              dm = (m_op == 8'h7C) ? 8 : 0;
            end
            rise_n++;
            last_rise = cyc;
          end
        end else begin
          half++;
        end
        if (!flash_sck) begin
          if (rise_n >= 8 && rise_n >= 8 + aw + dm) begin
            idx = rise_n - (8 + aw + dm);
            if (m_op == 8'h7C) begin
              flash_io_in = fdat(m_adr + idx);
            end else begin
              bt = fdat(m_adr + idx / 8);
              b  = bt[7 - idx % 8];
              flash_io_in = {{6{~b}}, b, ~b};
            end
          end else begin
            flash_io_in = 8'hFF;
          end
        end
      end
      prev_cs  = flash_cs_n;
      prev_sck = flash_sck;
    end
  end

  task automatic run_txn(input logic [1:0] m, input logic [31:0] a, input int len,
                         input int dv, input bit st, input bit poke, input bit chain);
    int t;
    t = 0;
    do begin @(negedge clk); t++; end while (!req_ready && t < 5000);
    exp_op    = (m == 2'd2) ? 8'h7C : (m == 2'd1) ? 8'h13 : 8'h03;
    exp_addr  = (m == 2'd1 || m == 2'd2) ? a : {8'h00, a[23:0]};
    exp_len   = (len == 0) ? 1 : len;
    exp_octal = (m == 2'd2);
    exp_div   = dv;
    exp_stall = st;
    exp_tag   = (m == 2'd0) ? "R2" : (m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : "R12";
    rx_idx = 0; done_cnt = 0;
    clk_div = 8'(dv); req_mode = m; req_addr = a; req_len = 16'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R10", "busy after accept", {busy, req_ready}, 2'b10);
    if (poke) begin
      repeat (6) @(negedge clk);
      req_mode = 2'd2; req_addr = 32'hDEADBEEF; req_len = 16'd9; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk(1'b0, "R8", "done timeout", t, 0);
    @(negedge clk);
    chk(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    chk(rx_idx == exp_len, "R8", "byte count", rx_idx, exp_len);
    if (!chain) begin
      repeat (6) @(negedge clk);
      chk(!busy && flash_cs_n && req_ready, "R10", "idle after done",
          {busy, flash_cs_n, req_ready}, 3'b011);
    end
  endtask

  typedef struct packed {
    logic [1:0]  m;
    logic [31:0] a;
    logic [15:0] n;
    logic [7:0]  d;
    logic        s;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 32'h0012_3456, 16'd4, 8'd0, 1'b0},
    '{2'd1, 32'h89AB_CDEF, 16'd3, 8'd1, 1'b0},
    '{2'd2, 32'h0000_0100, 16'd8, 8'd0, 1'b0},
    '{2'd2, 32'hFFFF_FFFE, 16'd5, 8'd2, 1'b1},
    '{2'd0, 32'hAB00_00FF, 16'd2, 8'd3, 1'b1},
    '{2'd3, 32'h0001_0203, 16'd2, 8'd0, 1'b0},
    '{2'd1, 32'h4000_0007, 16'd0, 8'd0, 1'b0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b1; req_mode = 2'd2; req_addr = 32'h1;
    req_len = 16'd1; clk_div = 8'd0;
    exp_stall = 0; exp_div = 0; exp_len = 0; exp_octal = 0;
    exp_op = 0; exp_addr = 0; exp_tag = "R1";
    cyc = 0; rx_idx = 0; done_cnt = 0; last_rise = 0;
    aw = 32; dm = 0; rise_n = 0; half = 0;
    repeat (3) @(negedge clk);
    chk(flash_cs_n && !flash_sck && flash_io_oe == 8'h00, "R1", "bus in reset",
        {flash_cs_n, flash_sck, flash_io_oe}, 10'h200);
    chk(!busy && !done && req_ready && !out_valid, "R1", "status in reset",
        {busy, done, req_ready, out_valid}, 4'b0010);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(flash_cs_n && !busy && req_ready && !flash_sck, "R1", "after release",
        {flash_cs_n, busy, req_ready, flash_sck}, 4'b1010);

    for (int i = 0; i < 7; i++)
      run_txn(VECS[i].m, VECS[i].a, int'(VECS[i].n), int'(VECS[i].d),
              VECS[i].s, 1'b0, 1'b0);

    // R10: requests while busy must be ignored
    run_txn(2'd0, 32'h0044_5566, 2, 2, 1'b0, 1'b1, 1'b0);
    // R9: back-to-back requests still see a deselect gap
    run_txn(2'd2, 32'h0000_1000, 3, 0, 1'b0, 1'b0, 1'b1);
    run_txn(2'd1, 32'h2000_0010, 2, 0, 1'b0, 1'b0, 1'b0);
    // R11 with octal data and a wider divider under stall
    run_txn(2'd2, 32'h0F0F_0F00, 6, 1, 1'b1, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule